// File: doc/BRIEF.md
# Timebase Interval Timer With Interrupt

This block is a counter that runs all the time and marks regular intervals. It counts base-clock cycles from a hardware reset, and a byte-wide control register picks one of eight power-of-two intervals. Each time the chosen interval ends, a sticky "elapsed" flag is set. An enable bit passes that flag on to the interrupt output. Software reads the register image, clears the flag by writing a 0 to it, and can reconfigure the interval, the enable and two spare storage bits in a single byte write.

The eight intervals come in two groups. Three short intervals start at `LOW_BASE`, and five long intervals start at `HIGH_BASE`. The gap between the groups is intended, so lowering both parameters keeps the shape of the tap set. A separate read-modify-write indication forces the flag to read as 1, so that a read-modify-write sequence writes the 1 back and cannot lose an event. A synchronous software reset clears only the flag and the enable. A hardware reset also returns the select, the spare bits and the counter to zero.

Top module: `tbt_timer`

## Requirements
- R1: The counter starts at zero on hardware reset and advances by one every cycle. The flag is set on the clock edge where the counter reaches a multiple of 2^n. Select code 000, 001 and 010 in bits 5:3 give n = LOW_BASE, LOW_BASE+1 and LOW_BASE+2. Codes 011 to 111 give n = HIGH_BASE to HIGH_BASE+4. The flag therefore sets every 2^n cycles, first 2^n cycles after reset.
- R2: The flag in bit 7 stays at 1 until it is cleared, whether the enable is set or not.
- R3: A write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag unchanged, whether it is 0 or 1.
- R4: If a clearing write and an interval end fall on the same edge, the flag ends at 1.
- R5: `irq` is 1 exactly when the enable in bit 6 and the flag are both 1.
- R6: A write stores bit 6, bits 5:3 and bits 1:0, and they read back unchanged.
- R7: Bit 2 ignores writes and always reads 0.
- R8: While `rmwRead` is 1, bit 7 of `rdData` reads 1. The stored flag is not changed.
- R9: Hardware reset (`rst`) sets bits 7:3 and 1:0 to 0 and restarts the counter from 0. It takes priority over everything else.
- R10: Software reset (`swRst`) clears bits 7 and 6 and overrides writes and interval ends. Bits 5:3, bits 1:0 and the counter keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| swRst | input | 1 | Synchronous software reset, active high |
| csHit | input | 1 | Register address decoded |
| wrStb | input | 1 | Write strobe, qualified by `csHit` |
| wrData | input | 8 | Write data byte |
| rmwRead | input | 1 | Read belongs to a read-modify-write sequence |
| rdData | output | 8 | Register image |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a clearing write that lands on the exact edge where an interval ends. The bench keeps its own model of the counter phase, taken from R1, and selects the shortest tap. It then raises the write strobe half a cycle before the edge where the low counter bits wrap. As a control case, it repeats the same write one cycle after the wrap, where the clear must win. The same phase model is used to show that a software reset leaves the interval rhythm in place, and that a hardware reset restarts it.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

  localparam int FLAG_BIT = 7;
  localparam int EN_BIT   = 6;
  localparam int SEL_MSB  = 5;
  localparam int SEL_LSB  = 3;
  localparam int RSV_BIT  = 2;
  localparam int SEL_W    = SEL_MSB - SEL_LSB + 1;
  localparam int NUM_TAPS = 1 << SEL_W;
  localparam int LOW_TAPS = 3;

  typedef struct packed {
    logic             cntClr;
    logic [SEL_W-1:0] tapSel;
  } tbt_ctl_t;

  function automatic int tapExp(input int code, input int lowBase, input int highBase);
    if (code < LOW_TAPS) return lowBase + code;
    return highBase + code - LOW_TAPS;
  endfunction

endpackage

// File: rtl/tbt_datapath.sv
module tbt_datapath
  import tbt_pkg::*;
#(
  parameter int LOW_BASE  = 11,
  parameter int HIGH_BASE = 22
) (
  input  logic     clk,
  input  tbt_ctl_t ctl,
  output logic     elapse
);

  localparam int CNT_W = tapExp(NUM_TAPS - 1, LOW_BASE, HIGH_BASE);

  logic [CNT_W-1:0]    cnt;
  logic [NUM_TAPS-1:0] tapHit;

  always_ff @(posedge clk) begin
    if (ctl.cntClr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // Each tap flags the cycle before a carry into its bit.
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam int EXPO = tapExp(k, LOW_BASE, HIGH_BASE);
    assign tapHit[k] = &cnt[EXPO-1:0];
  end

  assign elapse = tapHit[ctl.tapSel];

endmodule

// File: rtl/tbt_ctrl.sv
module tbt_ctrl
  import tbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       swRst,
  input  logic       csHit,
  input  logic       wrStb,
  input  logic [7:0] wrData,
  input  logic       rmwRead,
  input  logic       elapse,
  output tbt_ctl_t   ctl,
  output logic [7:0] regView,
  output logic [7:0] rdData,
  output logic       irq
);

  logic             flagQ;
  logic             enQ;
  logic [SEL_W-1:0] selQ;
  logic [1:0]       spareQ;
  logic             wrHit;
  logic             unusedRsv;

  assign wrHit     = csHit & wrStb;
  assign unusedRsv = wrData[RSV_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ <= 1'b0;
    end else if (swRst) begin
      flagQ <= 1'b0;
    end else if (elapse) begin
      flagQ <= 1'b1;
    end else if (wrHit && !wrData[FLAG_BIT]) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enQ    <= 1'b0;
      selQ   <= '0;
      spareQ <= '0;
    end else if (swRst) begin
      enQ <= 1'b0;
    end else if (wrHit) begin
      enQ    <= wrData[EN_BIT];
      selQ   <= wrData[SEL_MSB:SEL_LSB];
      spareQ <= wrData[1:0];
    end
  end

  assign ctl.cntClr = rst;
  assign ctl.tapSel = selQ;

  assign regView = {flagQ, enQ, selQ, 1'b0, spareQ};
  assign rdData  = {flagQ | rmwRead, regView[6:0]};
  assign irq     = flagQ & enQ;

endmodule

// File: rtl/tbt_timer.sv
module tbt_timer
  import tbt_pkg::*;
#(
  parameter int LOW_BASE  = 11,
  parameter int HIGH_BASE = 22
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       swRst,
  input  logic       csHit,
  input  logic       wrStb,
  input  logic [7:0] wrData,
  input  logic       rmwRead,
  output logic [7:0] rdData,
  output logic       irq
);

  tbt_ctl_t   ctl;
  logic       elapse;
  logic [7:0] regView;

  tbt_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .swRst   (swRst),
    .csHit   (csHit),
    .wrStb   (wrStb),
    .wrData  (wrData),
    .rmwRead (rmwRead),
    .elapse  (elapse),
    .ctl     (ctl),
    .regView (regView),
    .rdData  (rdData),
    .irq     (irq)
  );

  tbt_datapath #(
    .LOW_BASE  (LOW_BASE),
    .HIGH_BASE (HIGH_BASE)
  ) u_dp (
    .clk    (clk),
    .ctl    (ctl),
    .elapse (elapse)
  );

endmodule

// File: rtl/tbt_checker.sv
module tbt_checker (
  input logic       clk,
  input logic       rst,
  input logic       swRst,
  input logic       csHit,
  input logic       wrStb,
  input logic [7:0] wrData,
  input logic       rmwRead,
  input logic [7:0] rdData,
  input logic       irq,
  input logic       elapse,
  input logic [7:0] regView
);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (regView[7] && !swRst && !(csHit && wrStb && !wrData[7])) |=> regView[7]); // R2

  AST_WR1_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!regView[7] && csHit && wrStb && wrData[7] && !elapse && !swRst) |=> !regView[7]); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (elapse && !swRst) |=> regView[7]); // R4

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> rdData[6]); // R5

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
    (rdData[6] && regView[7]) |-> irq); // R5

  AST_WR_STORE: assert property (@(posedge clk) disable iff (rst)
    (csHit && wrStb && !swRst) |=>
      (regView[5:3] == $past(wrData[5:3]) && regView[1:0] == $past(wrData[1:0]))); // R6

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdData[2] == 1'b0); // R7

  AST_RMW_ONE: assert property (@(posedge clk) disable iff (rst)
    rmwRead |-> rdData[7]); // R8

  AST_HWRST: assert property (@(posedge clk)
    rst |=> (regView[7:3] == 5'd0 && regView[1:0] == 2'd0)); // R9

  AST_SWRST: assert property (@(posedge clk) disable iff (rst)
    swRst |=> (regView[7:6] == 2'd0 && regView[5:3] == $past(regView[5:3])
               && regView[1:0] == $past(regView[1:0]))); // R10

endmodule

bind tbt_timer tbt_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .swRst   (swRst),
  .csHit   (csHit),
  .wrStb   (wrStb),
  .wrData  (wrData),
  .rmwRead (rmwRead),
  .rdData  (rdData),
  .irq     (irq),
  .elapse  (elapse),
  .regView (regView)
);

// File: tb/sim_tbt_timer.sv
module sim_tbt_timer;

  localparam int CLK_PERIOD = 10;
  localparam int LOW_B  = 2;
  localparam int HIGH_B = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       swRst = 1'b0;
  logic       csHit = 1'b0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rmwRead = 1'b0;
  logic [7:0] rdData;
  logic       irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int unsigned tbCnt = 0;
  logic probe = 1'b0;

  typedef struct {
    logic [8:0] exp;
    logic [8:0] mask;
    string      tag;
  } item_t;

  item_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // counter phase model from R1 / R9
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) tbCnt <= 0;
    else     tbCnt <= tbCnt + 1;
  end

  tbt_timer #(.LOW_BASE(LOW_B), .HIGH_BASE(HIGH_B)) u0 (
    .clk(clk), .rst(rst), .swRst(swRst), .csHit(csHit), .wrStb(wrStb),
    .wrData(wrData), .rmwRead(rmwRead), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item when the driver probes
  always @(negedge clk) begin
    if (probe && sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      check(it.tag, int'({irq, rdData} & it.mask), int'(it.exp & it.mask));
    end
  end

  task automatic expectReg(input logic [8:0] exp, input logic [8:0] mask, input string tag);
    item_t it;
    it.exp = exp; it.mask = mask; it.tag = tag;
    @(posedge clk); #1;
    sbQ.push_back(it);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1;
    csHit = 1'b1; wrStb = 1'b1; wrData = d;
    @(posedge clk); #1;
    csHit = 1'b0; wrStb = 1'b0;
  endtask

  task automatic waitFlag();
    @(negedge clk);
    while (!rdData[7]) @(negedge clk);
  endtask

  task automatic measureTap(input int code);
    int t0;
    int expo;
    logic [7:0] cfg;
    expo = (code < 3) ? LOW_B + code : HIGH_B + code - 3;
    cfg = 8'h40 | 8'(code << 3);
    wr(cfg);
    waitFlag();
    wr(cfg);
    waitFlag();
    t0 = cyc;
    wr(cfg);
    waitFlag();
    check($sformatf("R1 period code %0d", code), cyc - t0, 1 << expo);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    expectReg(9'h000, 9'h1FF, "R9 reset state");

    wr(8'h3F);
    expectReg(9'h03B, 9'h17F, "R6 R7 readback, reserved reads 0");

    for (int c = 0; c < 8; c++) measureTap(c);

    expectReg(9'h1F8, 9'h1FF, "R5 irq with enable and flag");
    wr(8'hB8);
    expectReg(9'h0B8, 9'h1FF, "R5 irq low with enable off, R3 write 1 keeps flag");
    wr(8'h38);
    expectReg(9'h038, 9'h1FF, "R3 write 0 clears flag");
    wr(8'hB8);
    expectReg(9'h038, 9'h1FF, "R3 write 1 leaves cleared flag at 0");

    rmwRead = 1'b1;
    expectReg(9'h0B8, 9'h1FF, "R8 flag reads 1 in rmw read");
    rmwRead = 1'b0;
    expectReg(9'h038, 9'h1FF, "R8 stored flag unchanged");

    waitFlag();
    repeat (40) @(posedge clk);
    expectReg(9'h0B8, 9'h1FF, "R2 flag held with interrupt disabled");

    // R4: clear write on the wrap edge of the 000 tap
    wr(8'h00);
    @(negedge clk);
    while ((tbCnt & 3) != 3) @(negedge clk);
    csHit = 1'b1; wrStb = 1'b1; wrData = 8'h00;
    @(posedge clk); #1;
    csHit = 1'b0; wrStb = 1'b0;
    expectReg(9'h080, 9'h1FF, "R4 set wins over clear");
    @(negedge clk);
    while ((tbCnt & 3) != 0) @(negedge clk);
    csHit = 1'b1; wrStb = 1'b1; wrData = 8'h00;
    @(posedge clk); #1;
    csHit = 1'b0; wrStb = 1'b0;
    expectReg(9'h000, 9'h1FF, "R4 clear off the wrap edge");

    // R10: software reset keeps select, spare bits and counter phase
    wr(8'h6A);
    waitFlag();
    while ((tbCnt & 511) != 100) @(negedge clk);
    swRst = 1'b1;
    @(posedge clk); #1;
    swRst = 1'b0;
    expectReg(9'h02A, 9'h1FF, "R10 software reset fields");
    waitFlag();
    check("R10 counter phase kept", int'(tbCnt & 511), 0);

    // R9: hardware reset mid-run
    wr(8'h6B);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    expectReg(9'h000, 9'h1FF, "R9 hardware reset fields");
    waitFlag();
    check("R9 R1 counter restarts, first flag", int'(tbCnt), 4);

    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule